// File: doc/BRIEF.md
# Predicate Register File with Qualifying Gate

This block keeps 64 single-bit condition registers in place of a flags register. Compare operations write their outcome into these registers. Every issued operation names one of them as its qualifier, and the block returns an execute-enable that is high only when the named register holds true. Entry 0 is fixed at true. An operation that must always run therefore names entry 0 as its qualifier.

Results arrive through a compare port with two lanes. Lane A stores the compare result, and lane B stores its complement. Each lane has its own write enable and its own target index. A bulk port exposes the entire file as one 64-bit word, where bit i is entry i. Software uses it to save the predicate state across a context switch and to restore it. Entries 0 to 15 form a fixed group and entries 16 to 63 form an upper group. Each group is held in its own bank.

Top module: `pred_file`

## Requirements
- R1: After reset, `bulk_rdata` equals 64'h1: entry 0 reads true and every other entry reads false.
- R2: Entry 0 always reads 1. A compare write aimed at index 0, or a bulk write whose bit 0 is 0, leaves it at 1 and raises no error.
- R3: `exec_en` equals the current stored value of the entry selected by `qual_idx`. A write in the same cycle to that entry does not appear on `exec_en` until the cycle after the clock edge.
- R4: When `qual_idx` is 0, `exec_en` is 1.
- R5: When `cmp_we_a` is high, the entry at `cmp_idx_a` takes `cmp_result` at the next clock edge.
- R6: When `cmp_we_b` is high, the entry at `cmp_idx_b` takes the inverse of `cmp_result` at the next clock edge.
- R7: When both lanes are enabled and name the same index, lane A's value is stored.
- R8: `bulk_rdata` bit i is entry i. When `bulk_we` is high and neither compare lane writes, entries 1 to 63 take `bulk_wdata` bits 1 to 63 at the next edge.
- R9: When a bulk write and a compare write fall in the same cycle, the compare value wins for each index a lane targets. All other entries take the bulk value.
- R10: In a cycle with no write enable high, every entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we_a | input | 1 | Lane A write enable |
| cmp_idx_a | input | 6 | Lane A target entry |
| cmp_we_b | input | 1 | Lane B write enable |
| cmp_idx_b | input | 6 | Lane B target entry |
| cmp_result | input | 1 | Compare outcome; A stores it, B stores its inverse |
| bulk_we | input | 1 | Write the whole file from `bulk_wdata` |
| bulk_wdata | input | 64 | Packed file image to restore |
| bulk_rdata | output | 64 | Packed image of the current file |
| qual_idx | input | 6 | Qualifying entry of the issued operation |
| exec_en | output | 1 | High when the qualifying entry is true |

## Verification
Two pairs of functions can meet in one cycle. A bulk restore can coincide with compare writes, and the two compare lanes can target the same entry. The bench forces both collisions on purpose, including a collision with index 0. It judges the next-cycle image against a model that applies lane A over lane B over the bulk word. It also reads `exec_en` in the same cycle as a write to the qualifying entry, and expects the old value there.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int DEF_PRED_COUNT = 64;
    localparam int DEF_FIXED_COUNT = 16;

    // Source that supplies an entry's next value.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_BULK  = 2'd1,
        SRC_CMP_A = 2'd2,
        SRC_CMP_B = 2'd3
    } wsrc_e;

endpackage

// File: rtl/pred_wr_decode.sv
module pred_wr_decode #(
    parameter int N  = pred_pkg::DEF_PRED_COUNT,
    parameter int IW = $clog2(N)
) (
    input  logic                      cmp_we_a,
    input  logic [IW-1:0]             cmp_idx_a,
    input  logic                      cmp_we_b,
    input  logic [IW-1:0]             cmp_idx_b,
    input  logic                      bulk_we,
    output pred_pkg::wsrc_e [N-1:0]   src
);
    import pred_pkg::*;

    // Priority per entry: lane A, then lane B, then bulk, then hold.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (cmp_we_a && (int'(cmp_idx_a) == i)) begin
                src[i] = SRC_CMP_A;
            end else if (cmp_we_b && (int'(cmp_idx_b) == i)) begin
                src[i] = SRC_CMP_B;
            end else if (bulk_we) begin
                src[i] = SRC_BULK;
            end else begin
                src[i] = SRC_HOLD;
            end
        end
    end

endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
    parameter int CNT      = 16,
    parameter bit HAS_ZERO = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  pred_pkg::wsrc_e [CNT-1:0] src,
    input  logic                     cmp_result,
    input  logic [CNT-1:0]           bulk_wdata,
    output logic [CNT-1:0]           bits_q
);
    import pred_pkg::*;

    localparam logic [CNT-1:0] RST_VAL = HAS_ZERO ? CNT'(1) : '0;

    typedef struct packed {
        logic [CNT-1:0] bits;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < CNT; i++) begin
            unique case (src[i])
                SRC_CMP_A: state_d.bits[i] = cmp_result;
                SRC_CMP_B: state_d.bits[i] = ~cmp_result;
                SRC_BULK:  state_d.bits[i] = bulk_wdata[i];
                default:   state_d.bits[i] = state_q.bits[i];
            endcase
        end
        // The always-true entry drops every write.
        if (HAS_ZERO) begin
            state_d.bits[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.bits <= RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign bits_q = state_q.bits;

    // R10: an entry whose source is hold keeps its value.
    p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src[CNT-1] == SRC_HOLD) |=> $stable(bits_q[CNT-1]));

endmodule

// File: rtl/pred_qual_gate.sv
module pred_qual_gate #(
    parameter int N  = pred_pkg::DEF_PRED_COUNT,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pred_vec,
    input  logic [IW-1:0] qual_idx,
    output logic          exec_en
);
    always_comb begin
        exec_en = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(qual_idx) == i) begin
                exec_en = pred_vec[i];
            end
        end
    end
endmodule

// File: rtl/pred_file.sv
module pred_file #(
    parameter int N     = pred_pkg::DEF_PRED_COUNT,
    parameter int FIXED = pred_pkg::DEF_FIXED_COUNT,
    parameter int IW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_we_a,
    input  logic [IW-1:0] cmp_idx_a,
    input  logic          cmp_we_b,
    input  logic [IW-1:0] cmp_idx_b,
    input  logic          cmp_result,
    input  logic          bulk_we,
    input  logic [N-1:0]  bulk_wdata,
    output logic [N-1:0]  bulk_rdata,
    input  logic [IW-1:0] qual_idx,
    output logic          exec_en
);
    import pred_pkg::*;

    localparam int UPPER = N - FIXED;

    wsrc_e [N-1:0] src;

    pred_wr_decode #(.N(N), .IW(IW)) u_dec (
        .cmp_we_a (cmp_we_a),
        .cmp_idx_a(cmp_idx_a),
        .cmp_we_b (cmp_we_b),
        .cmp_idx_b(cmp_idx_b),
        .bulk_we  (bulk_we),
        .src      (src)
    );

    // One bank per group: fixed group holds the always-true entry.
    for (genvar g = 0; g < 2; g++) begin : g_grp
        localparam int BASE = (g == 0) ? 0 : FIXED;
        localparam int CNT  = (g == 0) ? FIXED : UPPER;
        pred_bank #(.CNT(CNT), .HAS_ZERO(g == 0)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src[BASE+CNT-1:BASE]),
            .cmp_result(cmp_result),
            .bulk_wdata(bulk_wdata[BASE+CNT-1:BASE]),
            .bits_q    (bulk_rdata[BASE+CNT-1:BASE])
        );
    end

    pred_qual_gate #(.N(N), .IW(IW)) u_gate (
        .pred_vec(bulk_rdata),
        .qual_idx(qual_idx),
        .exec_en (exec_en)
    );

    p_zero_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we_a && cmp_idx_a == '0) |=> bulk_rdata[0]);

    p_gate_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en == bulk_rdata[qual_idx]);

    p_uncond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_idx == '0) |-> exec_en);

    p_lane_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we_a && cmp_idx_a != '0) |=> bulk_rdata[$past(cmp_idx_a)] == $past(cmp_result));

    p_lane_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we_b && cmp_idx_b != '0 && !(cmp_we_a && cmp_idx_a == cmp_idx_b))
        |=> bulk_rdata[$past(cmp_idx_b)] == !$past(cmp_result));

    p_bulk_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_we && !cmp_we_a && !cmp_we_b)
        |=> bulk_rdata == {$past(bulk_wdata[N-1:1]), 1'b1});

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bulk_we && !cmp_we_a && !cmp_we_b) |=> $stable(bulk_rdata));

endmodule

// File: tb/pred_file_test.sv
module pred_file_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_we_a = 1'b0, cmp_we_b = 1'b0, cmp_result = 1'b0, bulk_we = 1'b0;
    logic [5:0]    cmp_idx_a = '0, cmp_idx_b = '0, qual_idx = '0;
    logic [N-1:0]  bulk_wdata = '0;
    logic [N-1:0]  bulk_rdata;
    logic          exec_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [N-1:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_file uut (
        .clk(clk), .rst_n(rst_n),
        .cmp_we_a(cmp_we_a), .cmp_idx_a(cmp_idx_a),
        .cmp_we_b(cmp_we_b), .cmp_idx_b(cmp_idx_b),
        .cmp_result(cmp_result), .bulk_we(bulk_we),
        .bulk_wdata(bulk_wdata), .bulk_rdata(bulk_rdata),
        .qual_idx(qual_idx), .exec_en(exec_en)
    );

    task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural next-state of the reference file.
    function automatic logic [N-1:0] ref_next(input logic [N-1:0] cur);
        logic [N-1:0] nxt = cur;
        if (bulk_we) nxt = bulk_wdata;
        if (cmp_we_b) nxt[cmp_idx_b] = ~cmp_result;
        if (cmp_we_a) nxt[cmp_idx_a] = cmp_result;
        nxt[0] = 1'b1;
        return nxt;
    endfunction

    // Apply one cycle of stimulus; inputs are set near the falling edge.
    task automatic cyc(input bit wa, input int ia, input bit wb, input int ib, input bit res,
                       input bit bw, input logic [N-1:0] bd, input int q, input string req);
        logic [N-1:0] nxt;
        cmp_we_a = wa; cmp_idx_a = 6'(ia);
        cmp_we_b = wb; cmp_idx_b = 6'(ib);
        cmp_result = res; bulk_we = bw; bulk_wdata = bd; qual_idx = 6'(q);
        #1;
        chk(exec_en == model[q], "R3 same-cycle gate", N'(exec_en), N'(model[q]));
        nxt = ref_next(model);
        @(posedge clk);
        model = nxt;
        @(negedge clk);
        chk(bulk_rdata == model, req, bulk_rdata, model);
        chk(exec_en == model[q], "R3 gate", N'(exec_en), N'(model[q]));
    endtask

    task automatic idle(input int q, input string req);
        cyc(0, 0, 0, 0, 0, 0, '0, q, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model = N'(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(bulk_rdata == N'(1), "R1 reset image", bulk_rdata, N'(1));
        chk(exec_en == 1'b1, "R4 reset qual 0", N'(exec_en), N'(1));
        @(negedge clk);

        // R5 / R6 on both groups
        cyc(1, 5, 1, 40, 1, 0, '0, 5, "R5 R6 lanes");
        cyc(1, 63, 1, 16, 0, 0, '0, 16, "R5 R6 inverted");
        // R7 collision
        cyc(1, 20, 1, 20, 1, 0, '0, 20, "R7 lane A wins");
        cyc(1, 20, 1, 20, 0, 0, '0, 20, "R7 lane A wins clear");
        // R2 writes to entry 0
        cyc(1, 0, 1, 0, 0, 0, '0, 0, "R2 cmp to zero");
        chk(bulk_rdata[0] == 1'b1, "R2 zero after cmp", N'(bulk_rdata[0]), N'(1));
        cyc(0, 0, 0, 0, 0, 1, 64'hFFFF_0000_AAAA_5554, 0, "R2 R8 bulk bit0 zero");
        chk(bulk_rdata[0] == 1'b1, "R2 zero after bulk", N'(bulk_rdata[0]), N'(1));
        // R4 with qual 0 while zero entry targeted
        cyc(0, 0, 1, 0, 1, 0, '0, 0, "R4 qual zero");
        chk(exec_en == 1'b1, "R4 exec_en", N'(exec_en), N'(1));
        // R8 full restore
        cyc(0, 0, 0, 0, 0, 1, 64'h0123_4567_89AB_CDEF, 9, "R8 restore");
        cyc(0, 0, 0, 0, 0, 1, '0, 3, "R8 clear all");
        // R9 bulk vs compare
        cyc(1, 7, 1, 50, 0, 1, '1, 50, "R9 cmp over bulk");
        chk(bulk_rdata[7] == 1'b0 && bulk_rdata[50] == 1'b1 && bulk_rdata[51] == 1'b1,
            "R9 targeted bits", bulk_rdata, model);
        // R3 no bypass: write qualifier entry, gate still shows old value
        cyc(1, 33, 0, 0, 1, 0, '0, 33, "R3 no bypass");
        cyc(1, 33, 0, 0, 0, 0, '0, 33, "R3 no bypass clear");
        // R10 idle holds
        for (int k = 0; k < 4; k++) idle(k * 15, "R10 hold");

        // Random traffic against the model
        for (int t = 0; t < 3000; t++) begin
            logic [N-1:0] w = {$urandom(), $urandom()};
            int r = int'($urandom() % 8);
            cyc(r[0], int'($urandom() % 64), r[1], int'($urandom() % 64), $urandom() % 2 == 1,
                r[2] && ($urandom() % 3 == 0), w, int'($urandom() % 64), "R8 R9 random image");
        end

        // Reset again returns to R1 image
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = N'(1);
        #1;
        chk(bulk_rdata == N'(1), "R1 second reset", bulk_rdata, N'(1));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule